// File: doc/BRIEF.md
# ADC Monotonicity Self-Test Checker

This block is an on-chip checker for a data converter's self-test. While a steadily rising ramp is applied to the converter's analog input, the checker watches the output codes that arrive with a sample strobe. It compares each code against the code taken on the sample before and counts the comparisons that come out right.

A test begins with a start pulse. The start pulse also captures three settings: the number of samples in the test, the count a healthy converter must reach, and whether strict mode is on. Once the programmed number of samples has been seen, the block raises its done flag. It then compares the final count with the expected count and gives a single go/no-go result.

The final count stays on its output until the next start, so it can be read for diagnosis. Strict mode also treats a step of more than one code as a failed comparison. This exposes missing codes as well as reversals. The ramp source is outside this block.

Top module: `adc_mono_bist`

## Requirements
- R1: While reset is asserted, and after it until the first start, done_o, pass_o and count_o are all 0.
- R2: A start_i pulse clears count_o, done_o and pass_o in the next cycle. It captures length_i, expect_i and strict_i for the test that follows. A strobe that arrives in the same cycle as start_i is ignored.
- R3: The first strobe after a start only loads the reference code. count_o stays 0 after it.
- R4: Every later strobe compares code_i, as an unsigned number, with the code from the previous strobe. If code_i is greater than or equal to that code, count_o goes up by one. If code_i is smaller, count_o is unchanged. In both cases code_i becomes the new reference.
- R5: In strict mode (strict_i high at start), a comparison succeeds only if code_i minus the reference is 0 or 1. A larger rising step is not counted.
- R6: The test ends on the strobe that brings the number of strobes since start to length_i. A length of 0 or 1 ends the test on the first strobe. done_o rises in the cycle after that strobe and not earlier.
- R7: When done_o rises, pass_o is 1 exactly when the final count equals the captured expect_i.
- R8: After done, done_o, pass_o and count_o hold their values until the next start, whatever strobes and codes arrive.
- R9: Without a start, count_o never changes by more than +1 from one cycle to the next.
- R10: pass_o is never 1 while done_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle pulse that begins a test |
| strobe_i | input | 1 | Marks a valid converter code in this cycle |
| code_i | input | CODE_W | Converter output code |
| expect_i | input | CNT_W | Count required for a pass, captured at start |
| length_i | input | CNT_W | Number of samples in the test, captured at start |
| strict_i | input | 1 | Strict missing-code mode, captured at start |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Go/no-go result, valid while done_o is high |
| count_o | output | CNT_W | Number of successful comparisons |

## Verification
The assertions assume that start_i is a single-cycle pulse and that a test's settings are driven in the start cycle. They also assume that strobes may arrive in any cycle, and that the counter cannot wrap because a test never holds more strobes than the count width can represent. The stimulus follows these assumptions. It drives short tests with strobe gaps, code reversals, repeated codes, jumps of two or more, a wrap from full scale down to zero, zero and unit lengths, and a start that collides with a strobe. A behavioural model then follows the same inputs on every clock.

// File: rtl/adc_mono_pkg.sv
package adc_mono_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } bist_state_e;
endpackage

// File: rtl/mono_cmp.sv
module mono_cmp #(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] ref_i,
  input  logic [CODE_W-1:0] cur_i,
  input  logic              strict_i,
  output logic              ok_o
);
  logic [CODE_W-1:0] step;
  logic              rising;

  always_comb begin
    rising = (cur_i >= ref_i);
    step   = cur_i - ref_i;
    ok_o   = rising && (!strict_i || (step <= CODE_W'(1)));
  end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import adc_mono_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] length_i,
  output logic             take_o,
  output logic             first_o,
  output logic             cmp_o,
  output logic             fin_o,
  output logic             done_o
);
  bist_state_e      state_q, state_d;
  logic [CNT_W-1:0] smp_q, smp_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             last;
  logic             en;

  always_comb begin
    state_d = state_q;
    smp_d   = smp_q;
    len_d   = len_q;
    take_o  = strobe_i && !start_i &&
              ((state_q == ST_FIRST) || (state_q == ST_RUN));
    first_o = take_o && (state_q == ST_FIRST);
    cmp_o   = take_o && (state_q == ST_RUN);
    last    = ({1'b0, smp_q} + (CNT_W+1)'(1)) >= {1'b0, len_q};
    fin_o   = take_o && last;
    if (start_i) begin
      state_d = ST_FIRST;
      smp_d   = '0;
      len_d   = length_i;
    end else if (take_o) begin
      smp_d   = smp_q + CNT_W'(1);
      state_d = last ? ST_DONE : ST_RUN;
    end
    en     = start_i || take_o;
    done_o = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      smp_q   <= '0;
      len_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      smp_q   <= smp_d;
      len_q   <= len_d;
    end
  end
endmodule

// File: rtl/score_unit.sv
module score_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             fin_i,
  input  logic [CNT_W-1:0] expect_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pass_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] exp_q, exp_d;
  logic             pass_q, pass_d;
  logic             en;

  always_comb begin
    cnt_d  = cnt_q;
    exp_d  = exp_q;
    pass_d = pass_q;
    if (clear_i) begin
      cnt_d  = '0;
      exp_d  = expect_i;
      pass_d = 1'b0;
    end else begin
      if (inc_i) cnt_d = cnt_q + CNT_W'(1);
      if (fin_i) pass_d = (cnt_d == exp_q);
    end
    en = clear_i || inc_i || fin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      exp_q  <= '0;
      pass_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      exp_q  <= exp_d;
      pass_q <= pass_d;
    end
  end

  assign count_o = cnt_q;
  assign pass_o  = pass_q;
endmodule

// File: rtl/adc_mono_bist.sv
module adc_mono_bist #(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  expect_i,
  input  logic [CNT_W-1:0]  length_i,
  input  logic              strict_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [CNT_W-1:0]  count_o
);
  logic              take, first_fire, cmp_fire, fin, ok;
  logic [CODE_W-1:0] ref_q;
  logic              strict_q;

  bist_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .strobe_i (strobe_i),
    .length_i (length_i),
    .take_o   (take),
    .first_o  (first_fire),
    .cmp_o    (cmp_fire),
    .fin_o    (fin),
    .done_o   (done_o)
  );

  mono_cmp #(.CODE_W(CODE_W)) u_cmp (
    .ref_i    (ref_q),
    .cur_i    (code_i),
    .strict_i (strict_q),
    .ok_o     (ok)
  );

  score_unit #(.CNT_W(CNT_W)) u_score (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .inc_i    (cmp_fire && ok),
    .fin_i    (fin),
    .expect_i (expect_i),
    .count_o  (count_o),
    .pass_o   (pass_o)
  );

  // Reference code: loaded on every accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else if (take) ref_q <= code_i;
  end

  // Mode captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strict_q <= 1'b0;
    else if (start_i) strict_q <= strict_i;
  end
endmodule

// File: rtl/adc_mono_bist_chk.sv
module adc_mono_bist_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             first_fire,
  input logic             done_o,
  input logic             pass_o,
  input logic [CNT_W-1:0] count_o
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == '0) && !done_o && !pass_o);

  // R3
  first_not_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_fire |=> (count_o == '0));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && $stable(count_o) && $stable(pass_o));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (count_o == $past(count_o)) ||
                 (count_o == $past(count_o) + CNT_W'(1)));

  // R10
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);
endmodule

bind adc_mono_bist adc_mono_bist_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .first_fire (first_fire),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .count_o    (count_o)
);

// File: tb/test_adc_mono_bist.sv
module test_adc_mono_bist;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              strobe_i = 1'b0;
  logic [CODE_W-1:0] code_i = '0;
  logic [CNT_W-1:0]  expect_i = '0;
  logic [CNT_W-1:0]  length_i = '0;
  logic              strict_i = 1'b0;
  logic              done_o, pass_o;
  logic [CNT_W-1:0]  count_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_mono_bist #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_adc_mono_bist (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(strobe_i),
    .code_i(code_i), .expect_i(expect_i), .length_i(length_i),
    .strict_i(strict_i), .done_o(done_o), .pass_o(pass_o), .count_o(count_o)
  );

  // Behavioural reference model: 0 idle, 1 waiting first, 2 running, 3 done
  int m_phase = 0, m_prev = 0, m_cnt = 0, m_seen = 0;
  int m_len = 0, m_exp = 0;
  bit m_strict = 0, m_pass = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_prev = 0; m_cnt = 0; m_seen = 0;
      m_len = 0; m_exp = 0; m_strict = 0; m_pass = 0;
    end else if (start_i) begin
      m_phase = 1; m_cnt = 0; m_seen = 0; m_pass = 0;
      m_len = int'(length_i); m_exp = int'(expect_i); m_strict = strict_i;
    end else if (strobe_i && (m_phase == 1 || m_phase == 2)) begin
      if (m_phase == 2) begin
        int c;
        c = int'(code_i);
        if (c >= m_prev && (!m_strict || (c - m_prev) <= 1)) m_cnt++;
      end
      m_prev = int'(code_i);
      m_seen++;
      if (m_seen >= m_len) begin
        m_phase = 3;
        m_pass = (m_cnt == m_exp);
      end else begin
        m_phase = 2;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 R6 R7 model done", int'(done_o), int'(m_phase == 3));
      check("R4 R6 R7 model pass", int'(pass_o), int'(m_pass));
      check("R4 R6 R7 model count", int'(count_o), m_cnt);
    end
  end

  task automatic begin_test(input int len, input int exp, input bit strict);
    @(negedge clk);
    start_i = 1'b1; length_i = CNT_W'(len); expect_i = CNT_W'(exp);
    strict_i = strict;
    @(negedge clk);
    start_i = 1'b0; strict_i = 1'b0; length_i = '0; expect_i = '0;
  endtask

  task automatic send(input int c, input int gap);
    strobe_i = 1'b1; code_i = CODE_W'(c);
    @(negedge clk);
    strobe_i = 1'b0; code_i = '0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset pass", int'(pass_o), 0);
    check("R1 reset count", int'(count_o), 0);
    rst_n = 1'b1;
    // strobes before any start are ignored
    send(5, 0); send(9, 0);
    check("R1 idle count", int'(count_o), 0);
    check("R1 idle done", int'(done_o), 0);

    // Clean ramp 0..9, length 10, expect 9
    begin_test(10, 9, 0);
    check("R2 start clears done", int'(done_o), 0);
    send(0, 0);
    check("R3 first strobe not counted", int'(count_o), 0);
    for (int i = 1; i < 9; i++) send(i, i % 3);
    check("R6 not done before last", int'(done_o), 0);
    check("R4 ramp count", int'(count_o), 8);
    send(9, 0);
    check("R6 done after last", int'(done_o), 1);
    check("R7 ramp pass", int'(pass_o), 1);
    check("R4 ramp final", int'(count_o), 9);

    // Hold after done
    send(3, 0); send(1, 1); send(0, 0);
    check("R8 hold count", int'(count_o), 9);
    check("R8 hold pass", int'(pass_o), 1);
    check("R8 hold done", int'(done_o), 1);

    // Reversal: 0,1,2,1,3,4 expect 5 -> count 4, fail
    begin_test(6, 5, 0);
    check("R2 restart count", int'(count_o), 0);
    check("R2 restart pass", int'(pass_o), 0);
    send(0, 0); send(1, 0); send(2, 2); send(1, 0); send(3, 0); send(4, 0);
    check("R4 reversal count", int'(count_o), 4);
    check("R7 reversal fail", int'(pass_o), 0);

    // Strict: 0,1,3,4,4,5 -> jump of 2 not counted -> 4
    begin_test(6, 5, 1);
    send(0, 0); send(1, 0); send(3, 0); send(4, 1); send(4, 0); send(5, 0);
    check("R5 strict count", int'(count_o), 4);
    check("R5 strict fail", int'(pass_o), 0);

    // Same codes non-strict -> 5, pass
    begin_test(6, 5, 0);
    send(0, 0); send(1, 0); send(3, 0); send(4, 1); send(4, 0); send(5, 0);
    check("R5 relaxed count", int'(count_o), 5);
    check("R5 relaxed pass", int'(pass_o), 1);

    // Strict near full scale, then wrap to zero is a decrease
    begin_test(4, 2, 1);
    send(1021, 0); send(1022, 0); send(1023, 0); send(0, 0);
    check("R5 top count", int'(count_o), 2);
    check("R4 wrap decrease", int'(pass_o), 1);

    // Length 0 and 1 end at the first strobe
    begin_test(0, 0, 0);
    check("R6 len0 waits", int'(done_o), 0);
    send(7, 0);
    check("R6 len0 done", int'(done_o), 1);
    check("R7 len0 pass", int'(pass_o), 1);
    begin_test(1, 1, 0);
    send(7, 0);
    check("R6 len1 done", int'(done_o), 1);
    check("R7 len1 fail", int'(pass_o), 0);

    // Strobe colliding with start is ignored
    @(negedge clk);
    start_i = 1'b1; strobe_i = 1'b1; code_i = CODE_W'(900);
    length_i = CNT_W'(3); expect_i = CNT_W'(2);
    @(negedge clk);
    start_i = 1'b0; strobe_i = 1'b0; code_i = '0; length_i = '0; expect_i = '0;
    check("R2 collide count", int'(count_o), 0);
    send(10, 0);
    check("R2 collide not done", int'(done_o), 0);
    send(11, 0); send(12, 0);
    check("R2 collide count final", int'(count_o), 2);
    check("R7 collide pass", int'(pass_o), 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule